// File: doc/BRIEF.md
# GF(32) Log-Domain Arithmetic Unit

This block is a registered arithmetic unit for the 32-element finite field built from the primitive polynomial x^5 + x^2 + 1. It is meant to sit inside a multi-error BCH decoder, where the syndrome, error-locator and root-search stages need field products, quotients, sums and conversions between the two usual forms of an element. Those forms are the exponent form k, meaning α^k with k in 0..30, and the 5-bit tuple form, whose bit i is the coefficient of α^i.

Products and quotients are formed by adding or subtracting exponents. The reduction modulo 31 is done by a generated fold table indexed by the raw 6-bit sum, so no modulo operator is used. Sums are formed by converting both exponent operands to tuples and XOR-ing them. The zero element has no exponent, so each operand carries a zero flag. Every accepted operation appears on the outputs exactly one clock later. The result is given in both forms, together with a zero flag and an error flag.

Top module: `gf32_log_alu`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first operation, `out_valid`, `out_zero`, `out_err`, `out_exp` and `out_tup` are all 0.
- R2: An operation presented with `in_valid` high at a clock edge shows its result with `out_valid` high right after the next edge. In a cycle without `in_valid`, `out_valid` drops and the result outputs keep their previous values.
- R3: Opcode 0 (multiply), with both operands nonzero, gives exponent (a+b) mod 31. For example, 5 and 11 give 16, 20 and 15 give 4, and 30 and 30 give 29.
- R4: A multiply with either zero flag set gives the zero element (`out_zero`=1, exponent and tuple 0) and no error.
- R5: Opcode 1 (divide a by b), with both operands nonzero, gives exponent (a-b) mod 31, wrapping up by 31 when negative. With a=0 this is the inverse of b. A zero dividend with a nonzero divisor gives the zero element.
- R6: A divide with the `b_zero` flag set raises `out_err` and gives the zero element.
- R7: Opcode 2 (add) XORs the tuples of the two exponent operands; a flagged operand counts as tuple 0. A tuple of 0 gives the zero element, and any other tuple is reported together with its exponent.
- R8: Opcode 4 (exp) turns exponent `a_val` into its tuple. For example, α^5 = 00101, α^7 = 10100 and α^0 = 00001, with bit 4 being the coefficient of α^4. With `a_zero` set, the result is the zero element.
- R9: Opcode 3 (log) takes `a_val` as a tuple and returns its exponent. It is the exact inverse of R8 for all 31 nonzero tuples. Tuple 0, or `a_zero` set, gives the zero element.
- R10: For a nonzero result, `out_exp` is in 0..30 (never 31) and `out_tup` is α^`out_exp`. For a zero result, both outputs are 0.
- R11: Opcodes 5, 6 and 7 are undefined. They raise `out_err` and give the zero element.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation present this cycle |
| op | input | 3 | Opcode: 0 mul, 1 div, 2 add, 3 log, 4 exp |
| a_val | input | 5 | Operand A (exponent; tuple for log) |
| a_zero | input | 1 | Operand A is the zero element |
| b_val | input | 5 | Operand B exponent |
| b_zero | input | 1 | Operand B is the zero element |
| out_valid | output | 1 | Result registered from the previous cycle |
| out_zero | output | 1 | Result is the zero element |
| out_err | output | 1 | Divide by zero or undefined opcode |
| out_exp | output | 5 | Result exponent form |
| out_tup | output | 5 | Result tuple form |

## Verification
The assertions assume that every operand read as an exponent lies in 0..30 whenever it is not flagged as zero. The value 31 is not a legal exponent, and feeding it to multiply or divide could let 31 reach the output. The bench follows this rule: it draws exponent operands only from 0..30 and uses all 32 codes only for the tuple operand of log. Random zero flags, undefined opcodes and idle cycles are mixed in so that the held-output and error paths are also covered.

// File: rtl/gf32_log_alu.sv
module gf32_log_alu #(
  parameter int M = 5,
  parameter logic [M-1:0] POLY_LOW = 5'b00101,
  parameter int OPW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [OPW-1:0] op,
  input  logic [M-1:0]   a_val,
  input  logic           a_zero,
  input  logic [M-1:0]   b_val,
  input  logic           b_zero,
  output logic           out_valid,
  output logic           out_zero,
  output logic           out_err,
  output logic [M-1:0]   out_exp,
  output logic [M-1:0]   out_tup
);
  localparam int N    = (1 << M) - 1;
  localparam int SW   = M + 1;
  localparam int NTAB = 1 << M;
  localparam int NFLD = 1 << SW;

  localparam logic [OPW-1:0] OP_MUL = OPW'(0);
  localparam logic [OPW-1:0] OP_DIV = OPW'(1);
  localparam logic [OPW-1:0] OP_ADD = OPW'(2);
  localparam logic [OPW-1:0] OP_LOG = OPW'(3);
  localparam logic [OPW-1:0] OP_EXP = OPW'(4);

  function automatic logic [M-1:0] pow_const(input int e);
    logic [M-1:0] t;
    t = M'(1);
    for (int i = 0; i < e; i++)
      t = t[M-1] ? ({t[M-2:0], 1'b0} ^ POLY_LOW) : {t[M-2:0], 1'b0};
    return t;
  endfunction

  function automatic logic [M-1:0] log_const(input int v);
    logic [M-1:0] r;
    r = '0;
    for (int i = 0; i < N; i++)
      if (pow_const(i) == M'(v)) r = M'(i);
    return r;
  endfunction

  logic [M-1:0] pow_rom  [NTAB];
  logic [M-1:0] log_rom  [NTAB];
  logic [M-1:0] fold_rom [NFLD];

  for (genvar i = 0; i < NTAB; i++) begin : g_tab
    assign pow_rom[i] = pow_const(i);
    assign log_rom[i] = log_const(i);
  end

  for (genvar s = 0; s < NFLD; s++) begin : g_fold
    assign fold_rom[s] = (s >= N) ? M'(s - N) : M'(s);
  end

  logic [M-1:0]  ta, tb, tx;
  logic [SW-1:0] sum, diff;

  assign ta   = a_zero ? '0 : pow_rom[a_val];
  assign tb   = b_zero ? '0 : pow_rom[b_val];
  assign tx   = ta ^ tb;
  assign sum  = {1'b0, a_val} + {1'b0, b_val};
  assign diff = {1'b0, a_val} + SW'(N) - {1'b0, b_val};

  logic         nz, nerr;
  logic [M-1:0] ne;

  always_comb begin
    nz   = 1'b0;
    nerr = 1'b0;
    ne   = '0;
    case (op)
      OP_MUL: begin
        nz = !a_zero && !b_zero;
        ne = fold_rom[sum];
      end
      OP_DIV: begin
        nerr = b_zero;
        nz   = !a_zero && !b_zero;
        ne   = fold_rom[diff];
      end
      OP_ADD: begin
        nz = tx != '0;
        ne = log_rom[tx];
      end
      OP_LOG: begin
        nz = !a_zero && a_val != '0;
        ne = log_rom[a_val];
      end
      OP_EXP: begin
        nz = !a_zero;
        ne = fold_rom[{1'b0, a_val}];
      end
      default: nerr = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_zero  <= 1'b0;
      out_err   <= 1'b0;
      out_exp   <= '0;
      out_tup   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_zero <= !nz;
        out_err  <= nerr;
        out_exp  <= nz ? ne : '0;
        out_tup  <= nz ? pow_rom[ne] : '0;
      end
    end
  end
endmodule

// File: rtl/gf32_log_alu_chk.sv
module gf32_log_alu_chk #(
  parameter int M = 5,
  parameter int OPW = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic [OPW-1:0] op,
  input logic           a_zero,
  input logic           b_zero,
  input logic           out_valid,
  input logic           out_zero,
  input logic           out_err,
  input logic [M-1:0]   out_exp,
  input logic [M-1:0]   out_tup
);
  localparam int N = (1 << M) - 1;

  AST_LATENCY_ON: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && $stable(out_exp) && $stable(out_tup) && $stable(out_zero)); // R2
  AST_MUL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op == OPW'(0) && (a_zero || b_zero) |=> out_zero && !out_err); // R4
  AST_DIV_BY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op == OPW'(1) && b_zero |=> out_err && out_zero); // R6
  AST_NO_EXP31: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_zero |-> out_exp != M'(N) && out_tup != '0); // R10
  AST_ZERO_FORM: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_zero |-> out_exp == '0 && out_tup == '0); // R10
  AST_BAD_OPCODE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op > OPW'(4) |=> out_err && out_zero); // R11
endmodule

bind gf32_log_alu gf32_log_alu_chk #(.M(M), .OPW(OPW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
  .a_zero(a_zero), .b_zero(b_zero), .out_valid(out_valid),
  .out_zero(out_zero), .out_err(out_err), .out_exp(out_exp), .out_tup(out_tup)
);

// File: tb/test_gf32_log_alu.sv
module test_gf32_log_alu;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n, in_valid, a_zero, b_zero;
  logic [2:0] op;
  logic [4:0] a_val, b_val;
  logic       out_valid, out_zero, out_err;
  logic [4:0] out_exp, out_tup;

  gf32_log_alu i_gf32_log_alu (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
    .a_val(a_val), .a_zero(a_zero), .b_val(b_val), .b_zero(b_zero),
    .out_valid(out_valid), .out_zero(out_zero), .out_err(out_err),
    .out_exp(out_exp), .out_tup(out_tup)
  );

  int checks = 0, errors = 0;
  int ptab[32];
  int ltab[32];
  bit e_valid = 0, e_zero = 0, e_err = 0;
  int e_exp = 0, e_tup = 0;
  string e_tag = "R1";

  function automatic string tag_of(input int o);
    case (o)
      0: return "R3";
      1: return "R5";
      2: return "R7";
      3: return "R9";
      4: return "R8";
      default: return "R11";
    endcase
  endfunction

  task automatic check_now();
    checks++;
    if (out_valid !== e_valid || out_zero !== e_zero || out_err !== e_err ||
        out_exp !== 5'(e_exp) || out_tup !== 5'(e_tup)) begin
      errors++;
      $display("FAIL %s: got v%0b z%0b e%0b exp%0d tup%05b, expected v%0b z%0b e%0b exp%0d tup%05b",
               e_tag, out_valid, out_zero, out_err, out_exp, out_tup,
               e_valid, e_zero, e_err, e_exp, 5'(e_tup));
    end
    if (out_valid && !out_zero) begin
      checks++;
      if (out_exp == 5'd31 || int'(out_tup) != ptab[out_exp]) begin
        errors++;
        $display("FAIL R10: got exp%0d tup%05b, expected exp<31 and tup=alpha^exp",
                 out_exp, out_tup);
      end
    end
  endtask

  task automatic apply(input int o, input int a, input bit az, input int b,
                       input bit bz, input bit v, input string tag);
    int t;
    in_valid = v; op = 3'(o); a_val = 5'(a); a_zero = az; b_val = 5'(b); b_zero = bz;
    e_valid = v;
    e_tag = tag;
    if (v) begin
      e_zero = 0; e_err = 0; e_exp = 0;
      case (o)
        0: if (az || bz) e_zero = 1; else e_exp = (a + b) % 31;
        1: if (bz) begin e_err = 1; e_zero = 1; end
           else if (az) e_zero = 1;
           else e_exp = (a - b + 31) % 31;
        2: begin
          t = (az ? 0 : ptab[a]) ^ (bz ? 0 : ptab[b]);
          if (t == 0) e_zero = 1; else e_exp = ltab[t];
        end
        3: if (az || a == 0) e_zero = 1; else e_exp = ltab[a];
        4: if (az) e_zero = 1; else e_exp = a;
        default: begin e_err = 1; e_zero = 1; end
      endcase
      e_tup = e_zero ? 0 : ptab[e_exp];
    end
    @(negedge clk);
    check_now();
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    int v;
    v = 1;
    ltab[0] = 0;
    ptab[31] = 1;
    for (int i = 0; i < 31; i++) begin
      ptab[i] = v;
      ltab[v] = i;
      v = v << 1;
      if (v & 32) v = v ^ 37;
    end

    rst_n = 0; in_valid = 0; op = 0; a_val = 0; b_val = 0; a_zero = 0; b_zero = 0;
    repeat (3) @(negedge clk);
    e_tag = "R1";
    check_now();
    rst_n = 1;
    apply(0, 0, 0, 0, 0, 0, "R1");

    apply(0, 5, 0, 11, 0, 1, "R3");
    apply(0, 20, 0, 15, 0, 1, "R3");
    apply(0, 30, 0, 30, 0, 1, "R3");
    apply(0, 0, 0, 0, 0, 1, "R3");
    apply(0, 9, 1, 4, 0, 1, "R4");
    apply(0, 9, 0, 4, 1, 1, "R4");
    apply(0, 9, 1, 4, 1, 1, "R4");
    apply(1, 3, 0, 7, 0, 1, "R5");
    apply(1, 12, 0, 12, 0, 1, "R5");
    apply(1, 0, 0, 1, 0, 1, "R5");
    apply(1, 30, 0, 0, 0, 1, "R5");
    apply(1, 6, 1, 2, 0, 1, "R5");
    apply(1, 6, 0, 2, 1, 1, "R6");
    apply(1, 6, 1, 2, 1, 1, "R6");
    apply(2, 0, 0, 2, 0, 1, "R7");
    apply(2, 17, 0, 17, 0, 1, "R7");
    apply(2, 17, 1, 8, 0, 1, "R7");
    apply(2, 17, 0, 8, 1, 1, "R7");
    apply(2, 1, 1, 8, 1, 1, "R7");
    apply(4, 7, 0, 0, 0, 1, "R8");
    apply(4, 5, 0, 0, 0, 1, "R8");
    apply(4, 0, 0, 0, 0, 1, "R8");
    apply(4, 7, 1, 0, 0, 1, "R8");
    apply(0, 0, 0, 0, 0, 0, "R2");
    apply(0, 4, 0, 4, 0, 0, "R2");
    for (int t = 0; t < 32; t++) apply(3, t, 0, 0, 0, 1, "R9");
    apply(3, 20, 1, 0, 0, 1, "R9");
    for (int e = 0; e < 31; e++) apply(4, e, 0, 0, 0, 1, "R8");
    apply(5, 3, 0, 3, 0, 1, "R11");
    apply(6, 3, 0, 3, 0, 1, "R11");
    apply(7, 3, 0, 3, 0, 1, "R11");
    apply(7, 3, 0, 3, 0, 0, "R2");

    for (int n = 0; n < 3000; n++) begin
      int o, a, b;
      bit az, bz, vv;
      o  = ($urandom % 10 == 0) ? 5 + $urandom % 3 : $urandom % 5;
      a  = (o == 3) ? $urandom % 32 : $urandom % 31;
      b  = $urandom % 31;
      az = ($urandom % 8) == 0;
      bz = ($urandom % 8) == 0;
      vv = ($urandom % 6) != 0;
      apply(o, a, az, b, bz, vv, vv ? tag_of(o) : "R2");
    end
    finish_run();
  end
endmodule